// File: doc/BRIEF.md
# Hub Downstream Port Power Controller

This block decides the power switch state and overcurrent status of two downstream hub ports. In the bus-side numbering these are ports 2 and 3, carried here as bit 0 and bit 1 of every per-port vector. The hub's request handler passes host requests to it as single-cycle pulses, one to turn a port's power on and one to turn it off. It also receives two raw overcurrent flags from the external power switches and two static mode selects. The block keeps one power control bit per port. It drives the switch enable pins from those bits and maintains the overcurrent indicator and change bits that the hub reports back.

One mode select chooses whether a single shared switch feeds both ports or each port has its own switch. The other chooses whether overcurrent is reported against the hub as a whole or against the individual port. The raw flags are synchronised and must stay high for a programmable filter time before they are accepted. Detection runs on the free clock and has no enable, so it keeps working while the hub is suspended. Any change to an indicator raises a pending flag. The next IN poll from the host reports that flag as a one-cycle pulse and clears it.

Top module: `hub_port_power`

## Requirements
- R1: After reset, every output is 0: power bits, pins, indicators, change bits, the pending flag and the report pulse.
- R2: A set_pwr_i[i] pulse sets power bit i and a clr_pwr_i[i] pulse clears it, visible after the next rising edge. When both arrive in the same cycle, the bit clears.
- R3: When gang_mode_i is 0 (individual switching), pwr_en_o[i] equals power bit i.
- R4: When gang_mode_i is 1, both pwr_en_o bits carry one shared enable. It is high while either power bit is set and drops only when both bits are clear.
- R5: A raw flag passes through two synchroniser flops. The indicator rises after the rising edge numbered filt_cycles_i+4, counting the edge that first samples the flag high, provided the flag stays high throughout. Any shorter high pulse is ignored.
- R6: When global_oc_i is 0 (per-port sensing), an accepted overcurrent on port i sets port_oc_o[i] and port_oc_chg_o[i] and clears only power bit i. The hub-level bits stay 0.
- R7: When global_oc_i is 1, an accepted overcurrent on either port sets hub_oc_o and hub_oc_chg_o and clears both power bits. port_oc_o and port_oc_chg_o stay 0.
- R8: An indicator follows its filtered flag. It clears on the fourth rising edge after the raw flag drops. Every change of an indicator, whether rise or fall, sets the matching change bit. Change bits hold until a clr_port_chg_i[i] or clr_hub_chg_i pulse clears them, and clearing a change bit leaves the indicator as it is.
- R9: Any indicator change sets chg_pend_o. An in_poll_i pulse while chg_pend_o is set gives a one-cycle status_rpt_o on the next edge and clears chg_pend_o. A poll with nothing pending gives no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gang_mode_i | input | 1 | 1: one shared switch, 0: one switch per port |
| global_oc_i | input | 1 | 1: hub-level overcurrent, 0: per-port overcurrent |
| filt_cycles_i | input | FILT_W | Overcurrent filter length in cycles |
| set_pwr_i | input | N_PORTS | Per-port power-on request pulse |
| clr_pwr_i | input | N_PORTS | Per-port power-off request pulse |
| clr_port_chg_i | input | N_PORTS | Clear the port overcurrent change bit |
| clr_hub_chg_i | input | 1 | Clear the hub overcurrent change bit |
| oc_flag_i | input | N_PORTS | Raw asynchronous overcurrent flags, active high |
| in_poll_i | input | 1 | IN poll on the status-change pipe |
| pwr_en_o | output | N_PORTS | Power switch enable pins |
| port_pwr_o | output | N_PORTS | Power control bits |
| port_oc_o | output | N_PORTS | Port overcurrent indicators |
| port_oc_chg_o | output | N_PORTS | Port overcurrent change bits |
| hub_oc_o | output | 1 | Hub overcurrent indicator |
| hub_oc_chg_o | output | 1 | Hub overcurrent change bit |
| chg_pend_o | output | 1 | Status change waiting to be reported |
| status_rpt_o | output | 1 | One-cycle report pulse for a pending change |

## Verification
The assertions assume that the mode selects change only between operating phases. Under that assumption, a cycle spent in a sensing mode means the other mode's change bits cannot gain new bits. They also assume that request pulses last one cycle. The bench applies a reset before each scenario, sets the modes while reset is held, and drives every request as a pulse of one clock that starts at a falling edge. Overcurrent flags are held for known numbers of cycles, either clearly shorter or clearly longer than the filter.

// File: rtl/hpp_pkg.sv
`timescale 1ns/1ps
package hpp_pkg;
  typedef enum logic {SW_INDIV = 1'b0, SW_GANG   = 1'b1} sw_mode_e;
  typedef enum logic {OC_PORT  = 1'b0, OC_GLOBAL = 1'b1} oc_mode_e;
endpackage

// File: rtl/hpp_oc_filter.sv
`timescale 1ns/1ps
module hpp_oc_filter #(
  parameter int FILT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_i,
  input  logic [FILT_W-1:0] limit_i,
  output logic              filt_o
);
  logic              s1_q, s2_q;
  logic [FILT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      cnt_q  <= '0;
      filt_o <= 1'b0;
    end else begin
      s1_q <= flag_i;
      s2_q <= s1_q;
      if (!s2_q) begin
        cnt_q  <= '0;
        filt_o <= 1'b0;
      end else if (!filt_o) begin
        if (cnt_q == limit_i) filt_o <= 1'b1;
        else                  cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R5: acceptance only from a synchronised high level
  p_accept_from_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filt_o) |-> $past(s2_q));
  // R8: a dropped synchronised flag releases the filter
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2_q |=> !filt_o);
endmodule

// File: rtl/hpp_status.sv
`timescale 1ns/1ps
module hpp_status #(
  parameter int N_PORTS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  hpp_pkg::oc_mode_e     oc_mode_i,
  input  logic [N_PORTS-1:0]    filt_i,
  input  logic [N_PORTS-1:0]    clr_port_chg_i,
  input  logic                  clr_hub_chg_i,
  input  logic                  in_poll_i,
  output logic [N_PORTS-1:0]    oc_hit_o,
  output logic [N_PORTS-1:0]    port_oc_o,
  output logic [N_PORTS-1:0]    port_chg_o,
  output logic                  hub_oc_o,
  output logic                  hub_chg_o,
  output logic                  pend_o,
  output logic                  rpt_o
);
  import hpp_pkg::*;

  logic [N_PORTS-1:0] port_tog, port_rise;
  logic               hub_tog, hub_rise, any_filt, evt;

  assign any_filt = |filt_i;

  always_comb begin
    port_tog  = '0;
    port_rise = '0;
    hub_tog   = 1'b0;
    hub_rise  = 1'b0;
    if (oc_mode_i == OC_GLOBAL) begin
      hub_tog  = any_filt ^ hub_oc_o;
      hub_rise = any_filt & ~hub_oc_o;
    end else begin
      port_tog  = filt_i ^ port_oc_o;
      port_rise = filt_i & ~port_oc_o;
    end
  end

  assign oc_hit_o = hub_rise ? '1 : port_rise;
  assign evt      = hub_tog | (|port_tog);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_oc_o  <= '0;
      port_chg_o <= '0;
      hub_oc_o   <= 1'b0;
      hub_chg_o  <= 1'b0;
      pend_o     <= 1'b0;
      rpt_o      <= 1'b0;
    end else begin
      if (oc_mode_i == OC_GLOBAL) begin
        hub_oc_o  <= any_filt;
        port_oc_o <= '0;
      end else begin
        hub_oc_o  <= 1'b0;
        port_oc_o <= filt_i;
      end
      // a new event outranks a clear in the same cycle
      port_chg_o <= (port_chg_o & ~clr_port_chg_i) | port_tog;
      hub_chg_o  <= (hub_chg_o & ~clr_hub_chg_i) | hub_tog;
      rpt_o      <= in_poll_i & pend_o;
      if (evt)            pend_o <= 1'b1;
      else if (in_poll_i) pend_o <= 1'b0;
    end
  end

  // R7: in global sensing the port change bits gain nothing
  p_port_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_mode_i == OC_GLOBAL) && $past(oc_mode_i == OC_GLOBAL)
      |-> ((port_chg_o & ~$past(port_chg_o)) == '0));
  // R6: in per-port sensing the hub change bit never rises
  p_hub_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_mode_i == OC_PORT) && $past(oc_mode_i == OC_PORT) |-> !$rose(hub_chg_o));
  // R9: a poll with no fresh event empties the pending flag
  p_poll_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_poll_i && !evt |=> !pend_o);
  // R9: a report needs something pending
  p_rpt_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_o |-> $past(pend_o) && $past(in_poll_i));
endmodule

// File: rtl/hpp_power.sv
`timescale 1ns/1ps
module hpp_power #(
  parameter int N_PORTS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  hpp_pkg::sw_mode_e     sw_mode_i,
  input  logic [N_PORTS-1:0]    set_i,
  input  logic [N_PORTS-1:0]    clr_i,
  input  logic [N_PORTS-1:0]    off_i,
  output logic [N_PORTS-1:0]    pwr_o,
  output logic [N_PORTS-1:0]    pin_o
);
  import hpp_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_o <= '0;
    else         pwr_o <= (pwr_o | set_i) & ~clr_i & ~off_i;
  end

  assign pin_o = (sw_mode_i == SW_GANG) ? {N_PORTS{|pwr_o}} : pwr_o;

  // R6: an overcurrent hit removes power from the hit ports
  p_oc_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|off_i) |=> ((pwr_o & $past(off_i)) == '0));
  // R4: the shared pin falls only when no port still wants power
  p_gang_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_mode_i == SW_GANG) && $past(sw_mode_i == SW_GANG) && $fell(pin_o[0])
      |-> (pwr_o == '0));
  // R2: a clear request always wins
  p_clear_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((pwr_o & $past(clr_i)) == '0));
endmodule

// File: rtl/hub_port_power.sv
`timescale 1ns/1ps
module hub_port_power #(
  parameter int N_PORTS = 2,
  parameter int FILT_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gang_mode_i,
  input  logic                global_oc_i,
  input  logic [FILT_W-1:0]   filt_cycles_i,
  input  logic [N_PORTS-1:0]  set_pwr_i,
  input  logic [N_PORTS-1:0]  clr_pwr_i,
  input  logic [N_PORTS-1:0]  clr_port_chg_i,
  input  logic                clr_hub_chg_i,
  input  logic [N_PORTS-1:0]  oc_flag_i,
  input  logic                in_poll_i,
  output logic [N_PORTS-1:0]  pwr_en_o,
  output logic [N_PORTS-1:0]  port_pwr_o,
  output logic [N_PORTS-1:0]  port_oc_o,
  output logic [N_PORTS-1:0]  port_oc_chg_o,
  output logic                hub_oc_o,
  output logic                hub_oc_chg_o,
  output logic                chg_pend_o,
  output logic                status_rpt_o
);
  import hpp_pkg::*;

  logic [N_PORTS-1:0] filt, oc_hit;
  sw_mode_e sw_mode;
  oc_mode_e oc_mode;

  assign sw_mode = sw_mode_e'(gang_mode_i);
  assign oc_mode = oc_mode_e'(global_oc_i);

  for (genvar i = 0; i < N_PORTS; i++) begin : g_filt
    hpp_oc_filter #(.FILT_W(FILT_W)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flag_i  (oc_flag_i[i]),
      .limit_i (filt_cycles_i),
      .filt_o  (filt[i])
    );
  end

  hpp_status #(.N_PORTS(N_PORTS)) u_status (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .oc_mode_i      (oc_mode),
    .filt_i         (filt),
    .clr_port_chg_i (clr_port_chg_i),
    .clr_hub_chg_i  (clr_hub_chg_i),
    .in_poll_i      (in_poll_i),
    .oc_hit_o       (oc_hit),
    .port_oc_o      (port_oc_o),
    .port_chg_o     (port_oc_chg_o),
    .hub_oc_o       (hub_oc_o),
    .hub_chg_o      (hub_oc_chg_o),
    .pend_o         (chg_pend_o),
    .rpt_o          (status_rpt_o)
  );

  hpp_power #(.N_PORTS(N_PORTS)) u_power (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_mode_i (sw_mode),
    .set_i     (set_pwr_i),
    .clr_i     (clr_pwr_i),
    .off_i     (oc_hit),
    .pwr_o     (port_pwr_o),
    .pin_o     (pwr_en_o)
  );

  // R3: individual switching mirrors the power bits on the pins
  p_indiv_pins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gang_mode_i |-> (pwr_en_o == port_pwr_o));
  // R7: a hub overcurrent leaves no port powered
  p_global_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    global_oc_i && $rose(hub_oc_o) |-> (port_pwr_o == '0));
endmodule

// File: tb/hub_port_power_test.sv
`timescale 1ns/1ps
module hub_port_power_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       gang_mode_i = 1'b0, global_oc_i = 1'b0;
  logic [7:0] filt_cycles_i = 8'd4;
  logic [1:0] set_pwr_i = '0, clr_pwr_i = '0, clr_port_chg_i = '0, oc_flag_i = '0;
  logic       clr_hub_chg_i = 1'b0, in_poll_i = 1'b0;
  logic [1:0] pwr_en_o, port_pwr_o, port_oc_o, port_oc_chg_o;
  logic       hub_oc_o, hub_oc_chg_o, chg_pend_o, status_rpt_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  hub_port_power uut (
    .clk_i, .rst_ni, .gang_mode_i, .global_oc_i, .filt_cycles_i,
    .set_pwr_i, .clr_pwr_i, .clr_port_chg_i, .clr_hub_chg_i,
    .oc_flag_i, .in_poll_i, .pwr_en_o, .port_pwr_o, .port_oc_o,
    .port_oc_chg_o, .hub_oc_o, .hub_oc_chg_o, .chg_pend_o, .status_rpt_o
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic restart(logic gang, logic glob, logic [7:0] filt);
    rst_ni = 1'b0;
    gang_mode_i = gang; global_oc_i = glob; filt_cycles_i = filt;
    set_pwr_i = '0; clr_pwr_i = '0; clr_port_chg_i = '0; clr_hub_chg_i = 1'b0;
    oc_flag_i = '0; in_poll_i = 1'b0;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic pulse_set(logic [1:0] m);
    set_pwr_i = m; tick(1); set_pwr_i = '0;
  endtask

  task automatic pulse_clr(logic [1:0] m);
    clr_pwr_i = m; tick(1); clr_pwr_i = '0;
  endtask

  task automatic t_reset;
    restart(1'b0, 1'b0, 8'd4);
    chk("R1", "pins", {6'd0, pwr_en_o}, 8'd0);
    chk("R1", "status", {port_pwr_o, port_oc_o, port_oc_chg_o, hub_oc_o, hub_oc_chg_o}, 8'd0);
    chk("R1", "pend/rpt", {6'd0, chg_pend_o, status_rpt_o}, 8'd0);
  endtask

  task automatic t_set_clear;
    restart(1'b0, 1'b0, 8'd4);
    pulse_set(2'b01);
    chk("R2", "set port2", {6'd0, port_pwr_o}, 8'd1);
    chk("R3", "indiv pins", {6'd0, pwr_en_o}, 8'd1);
    pulse_set(2'b10);
    chk("R3", "indiv pins both", {6'd0, pwr_en_o}, 8'd3);
    pulse_clr(2'b01);
    chk("R2", "clear port2", {6'd0, port_pwr_o}, 8'd2);
    set_pwr_i = 2'b01; clr_pwr_i = 2'b11; tick(1); set_pwr_i = '0; clr_pwr_i = '0;
    chk("R2", "clear wins", {6'd0, port_pwr_o}, 8'd0);
  endtask

  task automatic t_gang;
    restart(1'b1, 1'b0, 8'd4);
    pulse_set(2'b01);
    chk("R4", "shared on by port2", {6'd0, pwr_en_o}, 8'd3);
    pulse_set(2'b10);
    pulse_clr(2'b01);
    chk("R4", "held by port3", {6'd0, pwr_en_o}, 8'd3);
    pulse_clr(2'b10);
    chk("R4", "both clear", {6'd0, pwr_en_o}, 8'd0);
    pulse_set(2'b11);
    oc_flag_i = 2'b01;
    tick(8);
    chk("R4", "oc on port2, pins", {6'd0, pwr_en_o}, 8'd3);
    chk("R6", "oc on port2, bits", {6'd0, port_pwr_o}, 8'd2);
  endtask

  task automatic t_filter;
    restart(1'b0, 1'b0, 8'd4);
    oc_flag_i = 2'b01; tick(3); oc_flag_i = 2'b00;
    tick(10);
    chk("R5", "short pulse ignored", {4'd0, port_oc_o, port_oc_chg_o}, 8'd0);
    oc_flag_i = 2'b01;
    tick(7);
    chk("R5", "before filter end", {6'd0, port_oc_o}, 8'd0);
    tick(1);
    chk("R5", "at filter end", {6'd0, port_oc_o}, 8'd1);
    restart(1'b0, 1'b0, 8'd0);
    oc_flag_i = 2'b10;
    tick(3);
    chk("R5", "zero filter early", {6'd0, port_oc_o}, 8'd0);
    tick(1);
    chk("R5", "zero filter accept", {6'd0, port_oc_o}, 8'd2);
  endtask

  task automatic t_port_oc;
    restart(1'b0, 1'b0, 8'd4);
    pulse_set(2'b11);
    oc_flag_i = 2'b10;
    tick(8);
    chk("R6", "port3 indicator", {6'd0, port_oc_o}, 8'd2);
    chk("R6", "port3 change", {6'd0, port_oc_chg_o}, 8'd2);
    chk("R6", "hub bits quiet", {6'd0, hub_oc_o, hub_oc_chg_o}, 8'd0);
    chk("R6", "only port3 off", {6'd0, port_pwr_o}, 8'd1);
    oc_flag_i = 2'b00;
    tick(3);
    chk("R8", "indicator before release", {6'd0, port_oc_o}, 8'd2);
    tick(1);
    chk("R8", "indicator released", {6'd0, port_oc_o}, 8'd0);
    tick(5);
    chk("R8", "change sticky", {6'd0, port_oc_chg_o}, 8'd2);
    clr_port_chg_i = 2'b10; tick(1); clr_port_chg_i = '0;
    chk("R8", "change cleared", {6'd0, port_oc_chg_o}, 8'd0);
  endtask

  task automatic t_global_oc;
    restart(1'b0, 1'b1, 8'd4);
    pulse_set(2'b11);
    oc_flag_i = 2'b01;
    tick(8);
    chk("R7", "hub indicator+change", {6'd0, hub_oc_o, hub_oc_chg_o}, 8'd3);
    chk("R7", "port bits quiet", {4'd0, port_oc_o, port_oc_chg_o}, 8'd0);
    chk("R7", "both ports off", {6'd0, port_pwr_o}, 8'd0);
    clr_hub_chg_i = 1'b1; tick(1); clr_hub_chg_i = 1'b0;
    chk("R8", "hub change cleared, indicator kept", {6'd0, hub_oc_o, hub_oc_chg_o}, 8'd2);
  endtask

  task automatic t_report;
    restart(1'b0, 1'b0, 8'd0);
    in_poll_i = 1'b1; tick(1); in_poll_i = 1'b0;
    chk("R9", "idle poll", {6'd0, chg_pend_o, status_rpt_o}, 8'd0);
    oc_flag_i = 2'b01;
    tick(4);
    chk("R9", "pending set", {7'd0, chg_pend_o}, 8'd1);
    in_poll_i = 1'b1; tick(1); in_poll_i = 1'b0;
    chk("R9", "report pulse", {6'd0, chg_pend_o, status_rpt_o}, 8'd1);
    tick(1);
    chk("R9", "report one cycle", {7'd0, status_rpt_o}, 8'd0);
    in_poll_i = 1'b1; tick(1); in_poll_i = 1'b0;
    chk("R9", "second poll silent", {7'd0, status_rpt_o}, 8'd0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(1);
    t_reset;
    t_set_clear;
    t_gang;
    t_filter;
    t_port_oc;
    t_global_oc;
    t_report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule